// File: doc/BRIEF.md
# Region-Based Memory Access Checker

The checker sits beside a bus master and judges every access against a small set of programmable address windows. Each window carries its own attributes: a two-bit permission code, an execute-never bit, and a second execute-never bit that applies only to privileged fetches. A request gives the address, the access kind (read, write or instruction fetch) and the privilege level. One cycle later the checker answers with a grant or a fault and a cause code. The first fault is captured in a record that holds the address, the kind and the cause until software clears it.

Privileged software reloads the window set through a configuration port each time it switches between isolated software domains. One entry is normally left holding a window that stays valid across all switches, and peripheral windows get entries of their own. An address that hits no enabled window falls to a default rule. When that rule is on, it admits privileged accesses and faults unprivileged ones. Two enabled windows that both cover an address are treated as a configuration error, and the access faults; no priority decides between them.

Top module: `mem_access_guard`

## Requirements
- R1: After reset every window is disabled, the default rule is off, and resp_valid and flt_valid are low, so any access reports cause 1 (no match).
- R2: A window matches when enabled and base <= addr[ADDR_W-1:5] <= limit, both bounds inclusive in 32-byte units.
- R3: Permission code: 0 = read-only for privileged code, 1 = read-only for any privilege, 2 = read-write for privileged code, 3 = read-write for any privilege. An unprivileged access to a privileged-only window faults with cause 2, and so does a write to a read-only window.
- R4: A fetch from a window whose execute-never bit is set faults with cause 3 at either privilege level.
- R5: A fetch from a window whose privileged-execute-never bit is set faults with cause 3 when privileged and is granted when unprivileged. The execute checks take precedence over the permission check.
- R6: An access hitting no enabled window is granted if the default rule is on and the access is privileged. Otherwise it faults with cause 1.
- R7: An access hitting two or more enabled windows faults with cause 4.
- R8: Configuration writes (window entry or default rule) take effect only when cfg_priv is high. Unprivileged writes change nothing.
- R9: A window write takes effect for requests issued in the cycle after the write. A request issued in the same cycle as the write is judged on the old contents.
- R10: Every request yields resp_valid in the next cycle with resp_grant or a fault cause. resp_grant is never high without resp_valid, and resp_cause is 0 on a grant.
- R11: A fault loads flt_addr, flt_kind (0 read, 1 write, 2 fetch) and flt_cause into the record when the record is empty or is being cleared in that cycle. Otherwise the record holds its first fault until flt_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | Access made at privileged level |
| flt_clr | input | 1 | Clear the fault record |
| cfg_we | input | 1 | Write one window entry |
| cfg_priv | input | 1 | Configuration writer is privileged |
| cfg_idx | input | IDX_W | Window entry index |
| cfg_base | input | ADDR_W-5 | Window base, 32-byte units |
| cfg_limit | input | ADDR_W-5 | Window limit, inclusive, 32-byte units |
| cfg_en | input | 1 | Window enable |
| cfg_perm | input | 2 | Permission code |
| cfg_xn | input | 1 | Execute-never |
| cfg_pxn | input | 1 | Privileged execute-never |
| cfg_dflt_we | input | 1 | Write the default-rule enable |
| cfg_dflt_en | input | 1 | Default-rule enable value |
| resp_valid | output | 1 | Verdict present (one cycle after request) |
| resp_grant | output | 1 | Access granted |
| resp_cause | output | 3 | 0 none, 1 no match, 2 permission, 3 execute-never, 4 overlap |
| flt_valid | output | 1 | Fault record holds a fault |
| flt_addr | output | ADDR_W | Faulting address |
| flt_kind | output | 2 | Faulting access kind |
| flt_cause | output | 3 | Faulting cause |

## Verification
A corrupted window entry or a stuck default-rule flag appears at the ports on the very next request that touches the affected range. It shows as a wrong grant or a wrong cause one cycle after the request, so a vector sitting on each window's boundaries and in each window's interior exposes it at once. A fault record that is overwritten or not cleared becomes visible on the first fault that follows another fault with no clear in between. Mistimed configuration updates show up only when a request arrives in the same cycle as a write or in the cycle right after it, so both cases are driven deliberately.

// File: rtl/mag_pkg.sv
package mag_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_NOMATCH = 3'd1,
    CAUSE_PERM    = 3'd2,
    CAUSE_XN      = 3'd3,
    CAUSE_OVERLAP = 3'd4
  } flt_cause_e;

  // Permission code bits: [1] = writable, [0] = open to unprivileged code
  localparam int PERM_W     = 2;
  localparam int PERM_RW_B  = 1;
  localparam int PERM_ANY_B = 0;

endpackage

// File: rtl/mag_region_file.sv
module mag_region_file #(
  parameter int N_REG    = 8,
  parameter int FLD_W    = 27,
  parameter int IDX_W    = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic                                  cfg_priv,
  input  logic [IDX_W-1:0]                      cfg_idx,
  input  logic [FLD_W-1:0]                      cfg_base,
  input  logic [FLD_W-1:0]                      cfg_limit,
  input  logic                                  cfg_en,
  input  logic [mag_pkg::PERM_W-1:0]            cfg_perm,
  input  logic                                  cfg_xn,
  input  logic                                  cfg_pxn,
  input  logic                                  cfg_dflt_we,
  input  logic                                  cfg_dflt_en,
  output logic [N_REG-1:0][FLD_W-1:0]           rg_base,
  output logic [N_REG-1:0][FLD_W-1:0]           rg_limit,
  output logic [N_REG-1:0]                      rg_en,
  output logic [N_REG-1:0][mag_pkg::PERM_W-1:0] rg_perm,
  output logic [N_REG-1:0]                      rg_xn,
  output logic [N_REG-1:0]                      rg_pxn,
  output logic                                  dflt_en
);

  logic entry_wr_ok;
  logic dflt_wr_ok;
  logic dflt_en_q, dflt_en_d;

  assign entry_wr_ok = cfg_we && cfg_priv;
  assign dflt_wr_ok  = cfg_dflt_we && cfg_priv;

  for (genvar gi = 0; gi < N_REG; gi++) begin : g_entry
    logic                       sel;
    logic [FLD_W-1:0]           base_q, base_d;
    logic [FLD_W-1:0]           limit_q, limit_d;
    logic                       en_q, en_d;
    logic [mag_pkg::PERM_W-1:0] perm_q, perm_d;
    logic                       xn_q, xn_d;
    logic                       pxn_q, pxn_d;

    assign sel = entry_wr_ok && (cfg_idx == IDX_W'(gi));

    always_comb begin
      base_d  = base_q;
      limit_d = limit_q;
      en_d    = en_q;
      perm_d  = perm_q;
      xn_d    = xn_q;
      pxn_d   = pxn_q;
      if (sel) begin
        base_d  = cfg_base;
        limit_d = cfg_limit;
        en_d    = cfg_en;
        perm_d  = cfg_perm;
        xn_d    = cfg_xn;
        pxn_d   = cfg_pxn;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
        en_q    <= 1'b0;
        perm_q  <= '0;
        xn_q    <= 1'b0;
        pxn_q   <= 1'b0;
      end else if (sel) begin
        base_q  <= base_d;
        limit_q <= limit_d;
        en_q    <= en_d;
        perm_q  <= perm_d;
        xn_q    <= xn_d;
        pxn_q   <= pxn_d;
      end
    end

    assign rg_base[gi]  = base_q;
    assign rg_limit[gi] = limit_q;
    assign rg_en[gi]    = en_q;
    assign rg_perm[gi]  = perm_q;
    assign rg_xn[gi]    = xn_q;
    assign rg_pxn[gi]   = pxn_q;
  end

  always_comb begin
    dflt_en_d = dflt_en_q;
    if (dflt_wr_ok) dflt_en_d = cfg_dflt_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dflt_en_q <= 1'b0;
    else if (dflt_wr_ok) dflt_en_q <= dflt_en_d;
  end

  assign dflt_en = dflt_en_q;

  AST_CFG_UNPRIV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_priv |=> ($stable(rg_en) && $stable(rg_perm) && $stable(rg_base) &&
                   $stable(rg_limit) && $stable(rg_xn) && $stable(rg_pxn) &&
                   $stable(dflt_en)));  // R8

  AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_priv) |=> (rg_en[$past(cfg_idx)] == $past(cfg_en)));  // R9

endmodule

// File: rtl/mag_region_match.sv
module mag_region_match #(
  parameter int N_REG = 8,
  parameter int FLD_W = 27
) (
  input  logic [FLD_W-1:0]                      addr_fld,
  input  logic [N_REG-1:0][FLD_W-1:0]           rg_base,
  input  logic [N_REG-1:0][FLD_W-1:0]           rg_limit,
  input  logic [N_REG-1:0]                      rg_en,
  input  logic [N_REG-1:0][mag_pkg::PERM_W-1:0] rg_perm,
  input  logic [N_REG-1:0]                      rg_xn,
  input  logic [N_REG-1:0]                      rg_pxn,
  output logic [N_REG-1:0]                      hit,
  output logic                                  any_hit,
  output logic                                  multi_hit,
  output logic [mag_pkg::PERM_W-1:0]            sel_perm,
  output logic                                  sel_xn,
  output logic                                  sel_pxn
);

  for (genvar gi = 0; gi < N_REG; gi++) begin : g_cmp
    logic ge_base, le_limit;
    assign ge_base  = (addr_fld >= rg_base[gi]);
    assign le_limit = (addr_fld <= rg_limit[gi]);
    assign hit[gi]  = rg_en[gi] && ge_base && le_limit;
  end

  assign any_hit   = |hit;
  assign multi_hit = |(hit & (hit - N_REG'(1)));

  // One-hot select of the hit window's attributes; only meaningful
  // when exactly one window hits.
  always_comb begin
    sel_perm = '0;
    sel_xn   = 1'b0;
    sel_pxn  = 1'b0;
    for (int i = 0; i < N_REG; i++) begin
      if (hit[i]) begin
        sel_perm = sel_perm | rg_perm[i];
        sel_xn   = sel_xn   | rg_xn[i];
        sel_pxn  = sel_pxn  | rg_pxn[i];
      end
    end
  end

endmodule

// File: rtl/mag_decide.sv
module mag_decide (
  input  mag_pkg::acc_kind_e            kind,
  input  logic                          priv,
  input  logic                          any_hit,
  input  logic                          multi_hit,
  input  logic [mag_pkg::PERM_W-1:0]    sel_perm,
  input  logic                          sel_xn,
  input  logic                          sel_pxn,
  input  logic                          dflt_en,
  output logic                          grant,
  output mag_pkg::flt_cause_e           cause
);
  import mag_pkg::*;

  logic is_fetch, is_write, xn_block, perm_block;

  assign is_fetch   = (kind == ACC_FETCH);
  assign is_write   = (kind == ACC_WRITE);
  assign xn_block   = is_fetch && (sel_xn || (sel_pxn && priv));
  assign perm_block = (!priv && !sel_perm[PERM_ANY_B]) ||
                      (is_write && !sel_perm[PERM_RW_B]);

  always_comb begin
    grant = 1'b0;
    cause = CAUSE_NONE;
    if (multi_hit) begin
      cause = CAUSE_OVERLAP;
    end else if (any_hit) begin
      if (xn_block)        cause = CAUSE_XN;
      else if (perm_block) cause = CAUSE_PERM;
      else                 grant = 1'b1;
    end else if (dflt_en && priv) begin
      grant = 1'b1;
    end else begin
      cause = CAUSE_NOMATCH;
    end
  end

endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard #(
  parameter int N_REG    = 8,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LOG = 5,
  localparam int FLD_W   = ADDR_W - GRAN_LOG,
  localparam int IDX_W   = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  input  logic              flt_clr,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [FLD_W-1:0]  cfg_base,
  input  logic [FLD_W-1:0]  cfg_limit,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_perm,
  input  logic              cfg_xn,
  input  logic              cfg_pxn,
  input  logic              cfg_dflt_we,
  input  logic              cfg_dflt_en,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [2:0]        resp_cause,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [1:0]        flt_kind,
  output logic [2:0]        flt_cause
);
  import mag_pkg::*;

  logic [N_REG-1:0][FLD_W-1:0]  rg_base, rg_limit;
  logic [N_REG-1:0]             rg_en, rg_xn, rg_pxn;
  logic [N_REG-1:0][PERM_W-1:0] rg_perm;
  logic                         dflt_en;

  logic [N_REG-1:0]  hit;
  logic              any_hit, multi_hit, sel_xn, sel_pxn;
  logic [PERM_W-1:0] sel_perm;

  acc_kind_e  kind;
  logic       dec_grant;
  flt_cause_e dec_cause;

  mag_region_file #(.N_REG(N_REG), .FLD_W(FLD_W), .IDX_W(IDX_W)) u_file (
    .clk, .rst_n, .cfg_we, .cfg_priv, .cfg_idx, .cfg_base, .cfg_limit,
    .cfg_en, .cfg_perm, .cfg_xn, .cfg_pxn, .cfg_dflt_we, .cfg_dflt_en,
    .rg_base, .rg_limit, .rg_en, .rg_perm, .rg_xn, .rg_pxn, .dflt_en
  );

  mag_region_match #(.N_REG(N_REG), .FLD_W(FLD_W)) u_match (
    .addr_fld (req_addr[ADDR_W-1:GRAN_LOG]),
    .rg_base, .rg_limit, .rg_en, .rg_perm, .rg_xn, .rg_pxn,
    .hit, .any_hit, .multi_hit, .sel_perm, .sel_xn, .sel_pxn
  );

  assign kind = acc_kind_e'(req_kind);

  mag_decide u_decide (
    .kind, .priv (req_priv), .any_hit, .multi_hit, .sel_perm, .sel_xn,
    .sel_pxn, .dflt_en, .grant (dec_grant), .cause (dec_cause)
  );

  // Response register
  logic       rv_q, rv_d, rg_q, rg_d;
  logic [2:0] rc_q, rc_d;

  always_comb begin
    rv_d = req_valid;
    rg_d = req_valid && dec_grant;
    rc_d = req_valid ? 3'(dec_cause) : 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rg_q <= 1'b0;
      rc_q <= '0;
    end else begin
      rv_q <= rv_d;
      rg_q <= rg_d;
      rc_q <= rc_d;
    end
  end

  // Fault record
  logic              fv_q, fv_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic [1:0]        fk_q, fk_d;
  logic [2:0]        fc_q, fc_d;
  logic              new_flt, capture, rec_en;

  assign new_flt = req_valid && !dec_grant;
  assign capture = new_flt && (!fv_q || flt_clr);
  assign rec_en  = capture || flt_clr;

  always_comb begin
    fv_d = fv_q;
    fa_d = fa_q;
    fk_d = fk_q;
    fc_d = fc_q;
    if (capture) begin
      fv_d = 1'b1;
      fa_d = req_addr;
      fk_d = req_kind;
      fc_d = 3'(dec_cause);
    end else if (flt_clr) begin
      fv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      fa_q <= '0;
      fk_q <= '0;
      fc_q <= '0;
    end else if (rec_en) begin
      fv_q <= fv_d;
      fa_q <= fa_d;
      fk_q <= fk_d;
      fc_q <= fc_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_grant = rg_q;
  assign resp_cause = rc_q;
  assign flt_valid  = fv_q;
  assign flt_addr   = fa_q;
  assign flt_kind   = fk_q;
  assign flt_cause  = fc_q;

  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    resp_grant |-> (resp_valid && resp_cause == 3'd0));  // R10

  AST_REQ_GETS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);  // R10

  AST_OVERLAP_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && multi_hit) |=> (!resp_grant && resp_cause == 3'd4));  // R7

  AST_UNPRIV_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_hit && !req_priv) |=> (resp_valid && !resp_grant));  // R6

  AST_WRITE_RO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == ACC_WRITE && any_hit && !multi_hit &&
     !sel_perm[PERM_RW_B]) |=> !resp_grant);  // R3

  AST_XN_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == ACC_FETCH && $onehot0(hit) && any_hit && sel_xn)
      |=> (resp_cause == 3'd3));  // R4

  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clr) |=> (flt_valid && $stable(flt_addr) &&
                                 $stable(flt_cause) && $stable(flt_kind)));  // R11

endmodule

// File: tb/mem_access_guard_tb.sv
module mem_access_guard_tb_top;

  localparam int ADDR_W = 32;
  localparam int FLD_W  = 27;
  localparam int IDX_W  = 3;
  localparam int VW     = 39;
  localparam int NV     = 21;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_priv, flt_clr;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_kind;
  logic              cfg_we, cfg_priv, cfg_en, cfg_xn, cfg_pxn;
  logic [IDX_W-1:0]  cfg_idx;
  logic [FLD_W-1:0]  cfg_base, cfg_limit;
  logic [1:0]        cfg_perm;
  logic              cfg_dflt_we, cfg_dflt_en;
  logic              resp_valid, resp_grant, flt_valid;
  logic [2:0]        resp_cause, flt_cause;
  logic [ADDR_W-1:0] flt_addr;
  logic [1:0]        flt_kind;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  mem_access_guard dut_i (
    .clk, .rst_n, .req_valid, .req_addr, .req_kind, .req_priv, .flt_clr,
    .cfg_we, .cfg_priv, .cfg_idx, .cfg_base, .cfg_limit, .cfg_en, .cfg_perm,
    .cfg_xn, .cfg_pxn, .cfg_dflt_we, .cfg_dflt_en,
    .resp_valid, .resp_grant, .resp_cause,
    .flt_valid, .flt_addr, .flt_kind, .flt_cause
  );

  // {kind[2], priv, addr[32], exp_grant, exp_cause[3]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h0000_0100, 1'b0, 3'd2},  // R3 unpriv read of priv-only RW
    {2'd1, 1'b1, 32'h0000_0100, 1'b1, 3'd0},  // R3 priv write
    {2'd2, 1'b1, 32'h0000_0100, 1'b1, 3'd0},  // R4 priv fetch, no XN
    {2'd2, 1'b1, 32'h0000_1000, 1'b0, 3'd3},  // R5 priv fetch, PXN
    {2'd2, 1'b0, 32'h0000_1FFC, 1'b1, 3'd0},  // R5 unpriv fetch, PXN, limit edge
    {2'd1, 1'b0, 32'h0000_1004, 1'b0, 3'd2},  // R3 write to read-only
    {2'd2, 1'b0, 32'h0000_2000, 1'b0, 3'd3},  // R4 XN fetch unpriv
    {2'd0, 1'b0, 32'h0000_2FFF, 1'b1, 3'd0},  // R2 last byte of window
    {2'd1, 1'b0, 32'h0000_3000, 1'b1, 3'd0},  // R3 any RW write
    {2'd2, 1'b1, 32'h0000_3004, 1'b0, 3'd3},  // R4 XN fetch priv
    {2'd1, 1'b0, 32'h0000_401F, 1'b1, 3'd0},  // R2 peripheral window limit
    {2'd0, 1'b0, 32'h0000_4020, 1'b0, 3'd1},  // R6 just above window, unpriv
    {2'd0, 1'b1, 32'h0000_4020, 1'b1, 3'd0},  // R6 default rule grants priv
    {2'd0, 1'b1, 32'h0000_5000, 1'b1, 3'd0},  // R3 priv RO read
    {2'd1, 1'b1, 32'h0000_5000, 1'b0, 3'd2},  // R3 priv RO write
    {2'd0, 1'b0, 32'h0000_5000, 1'b0, 3'd2},  // R3 unpriv on priv RO
    {2'd0, 1'b0, 32'h0000_6000, 1'b0, 3'd1},  // R2 disabled window
    {2'd2, 1'b1, 32'h0000_6000, 1'b1, 3'd0},  // R6 default priv fetch
    {2'd0, 1'b0, 32'h0000_3810, 1'b0, 3'd4},  // R7 overlap
    {2'd0, 1'b1, 32'h0000_3900, 1'b1, 3'd0},  // R7 just past overlap
    {2'd0, 1'b0, 32'h0000_0FE0, 1'b0, 3'd2}   // R2 top granule of window 0
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [31:0] lo,
                           input logic [31:0] hi, input logic en,
                           input logic [1:0] perm, input logic xn,
                           input logic pxn, input logic priv);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_priv  = priv;
    cfg_idx   = IDX_W'(idx);
    cfg_base  = lo[31:5];
    cfg_limit = hi[31:5];
    cfg_en    = en;
    cfg_perm  = perm;
    cfg_xn    = xn;
    cfg_pxn   = pxn;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_priv  = 1'b0;
  endtask

  task automatic dflt_write(input logic val);
    @(negedge clk);
    cfg_dflt_we = 1'b1;
    cfg_priv    = 1'b1;
    cfg_dflt_en = val;
    @(negedge clk);
    cfg_dflt_we = 1'b0;
    cfg_priv    = 1'b0;
  endtask

  task automatic do_req(input logic [1:0] kind, input logic priv,
                        input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_priv  = priv;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clear_flt();
    @(negedge clk);
    flt_clr = 1'b1;
    @(negedge clk);
    flt_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_priv = 0; req_addr = '0; req_kind = '0; flt_clr = 0;
    cfg_we = 0; cfg_priv = 0; cfg_idx = '0; cfg_base = '0; cfg_limit = '0;
    cfg_en = 0; cfg_perm = '0; cfg_xn = 0; cfg_pxn = 0;
    cfg_dflt_we = 0; cfg_dflt_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 resp_valid", 32'(resp_valid), 32'd0);
    check("R1 flt_valid", 32'(flt_valid), 32'd0);
    do_req(2'd0, 1'b1, 32'h0000_0100);
    check("R1 priv read after reset", 32'(resp_cause), 32'd1);
    check("R10 resp_valid", 32'(resp_valid), 32'd1);
    clear_flt();

    // Window set for one domain
    cfg_write(0, 32'h0000_0000, 32'h0000_0FFF, 1, 2'd2, 0, 0, 1);
    cfg_write(1, 32'h0000_1000, 32'h0000_1FFF, 1, 2'd1, 0, 1, 1);
    cfg_write(2, 32'h0000_2000, 32'h0000_2FFF, 1, 2'd1, 1, 0, 1);
    cfg_write(3, 32'h0000_3000, 32'h0000_3FFF, 1, 2'd3, 1, 0, 1);
    cfg_write(4, 32'h0000_4000, 32'h0000_401F, 1, 2'd3, 1, 0, 1);
    cfg_write(5, 32'h0000_5000, 32'h0000_5FFF, 1, 2'd0, 0, 0, 1);
    cfg_write(6, 32'h0000_6000, 32'h0000_6FFF, 0, 2'd3, 0, 0, 1);
    cfg_write(7, 32'h0000_3800, 32'h0000_38FF, 1, 2'd3, 1, 0, 1);
    dflt_write(1'b1);

    for (int v = 0; v < NV; v++) begin
      logic [1:0]  k;
      logic        p, g;
      logic [31:0] a;
      logic [2:0]  c;
      {k, p, a, g, c} = VEC[v];
      do_req(k, p, a);
      check("R10 vector resp_valid", 32'(resp_valid), 32'd1);
      check($sformatf("R3-R7 vector %0d grant", v), 32'(resp_grant), 32'(g));
      check($sformatf("R3-R7 vector %0d cause", v), 32'(resp_cause), 32'(c));
      if (!g) begin
        check("R11 flt_valid", 32'(flt_valid), 32'd1);
        check("R11 flt_addr", flt_addr, a);
        check("R11 flt_kind", 32'(flt_kind), 32'(k));
        check("R11 flt_cause", 32'(flt_cause), 32'(c));
        clear_flt();
        check("R11 cleared", 32'(flt_valid), 32'd0);
      end
    end

    // R11: first fault held while a second one arrives
    do_req(2'd0, 1'b0, 32'h0000_0100);
    do_req(2'd2, 1'b1, 32'h0000_2000);
    check("R11 second fault cause", 32'(resp_cause), 32'd3);
    check("R11 held cause", 32'(flt_cause), 32'd2);
    check("R11 held addr", flt_addr, 32'h0000_0100);
    check("R11 held kind", 32'(flt_kind), 32'd0);
    clear_flt();
    check("R11 clear", 32'(flt_valid), 32'd0);

    // R8: unprivileged config writes are ignored
    cfg_write(6, 32'h0000_6000, 32'h0000_6FFF, 1, 2'd3, 0, 0, 0);
    do_req(2'd0, 1'b0, 32'h0000_6000);
    check("R8 unpriv entry write ignored", 32'(resp_cause), 32'd1);
    clear_flt();
    @(negedge clk);
    cfg_dflt_we = 1'b1; cfg_priv = 1'b0; cfg_dflt_en = 1'b0;
    @(negedge clk);
    cfg_dflt_we = 1'b0;
    do_req(2'd0, 1'b1, 32'h0000_9000);
    check("R8 unpriv default write ignored", 32'(resp_grant), 32'd1);

    // R9: same-cycle request sees old entry, next cycle sees new one
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_idx = 3'd6;
    cfg_base = 27'h300; cfg_limit = 27'h37F; cfg_en = 1'b1;
    cfg_perm = 2'd3; cfg_xn = 1'b0; cfg_pxn = 1'b0;
    req_valid = 1'b1; req_kind = 2'd0; req_priv = 1'b0; req_addr = 32'h0000_6000;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
    check("R9 same-cycle uses old", 32'(resp_cause), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next-cycle uses new", 32'(resp_grant), 32'd1);
    clear_flt();

    // R6: default rule off faults privileged unmatched access
    dflt_write(1'b0);
    do_req(2'd0, 1'b1, 32'h0000_9000);
    check("R6 default off priv", 32'(resp_cause), 32'd1);
    clear_flt();

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule